// File: doc/BRIEF.md
# Pixel Row Hit Finder with Pedestal Subtraction

The block takes one pixel row at a time from a readout front end. Each column gives two digitized samples. The first sample holds signal plus pedestal and the second holds pedestal only. For every column the block subtracts the second sample from the first, which leaves the pedestal-free amplitude. It compares that amplitude with a programmable threshold and keeps only the pixels that pass. For each pixel that passes, it writes one entry into an on-chip hit memory. The entry holds the row, the column and the amplitude. Pixels that do not pass are discarded as the row streams in, so no frame buffer is needed.

A row arrives as a series of beats, each beat carrying `LANES` adjacent columns. With `LANES` equal to `N_COLS` the whole row arrives in one beat (parallel input). With a smaller `LANES` the row is serialized into `N_COLS/LANES` beats. When a beat holds several hits, the block writes them one per cycle in ascending column order. While it does so it holds off further input through a ready signal. After each frame, a host reads the stored entries through a synchronous read port and then clears the memory.

Top module: `cds_hit_finder`

## Requirements
- R1: After reset the state is as follows: `hit_count_o` is 0, `overflow_o` is 0, `in_ready_o` is 1 and the threshold is 0.
- R2: The amplitude of a column is the signed difference first sample minus second sample. A stored entry reads `{row, column, amplitude}`, with the amplitude in bits [7:0], the column in the next COL_W bits, and the row in the top ROW_W bits.
- R3: A column is a hit only when its difference is strictly greater than the threshold. A difference equal to the threshold is not stored.
- R4: A zero or negative difference is never stored, even with a threshold of 0.
- R5: A cycle with `thr_we_i` high loads `thr_i` into the threshold register. Every beat accepted after that edge is judged against the new value.
- R6: The column address is beat index × LANES + lane. The beat index starts at 0, advances on each accepted beat and wraps after `N_COLS/LANES` beats. The row address is `in_row_i` of the beat.
- R7: Hits are stored at consecutive addresses from 0 in arrival order. Within a row they are in ascending column order.
- R8: One entry is written per cycle. After a beat is accepted, `in_ready_o` stays low while more than one of that beat's hits is still unwritten.
- R9: `hit_count_o` counts stored entries and never exceeds DEPTH. A hit that arrives with the memory full is dropped and sets `overflow_o`. `overflow_o` stays set until the frame is cleared.
- R10: A pulse on `frame_clr_i` sets `hit_count_o` and `overflow_o` to 0 on the next cycle. The next hit is then stored at address 0.
- R11: `rd_data_o` shows the entry at `rd_addr_i` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thr_we_i | input | 1 | Threshold load strobe |
| thr_i | input | 8 | Threshold value |
| in_valid_i | input | 1 | Beat valid |
| in_ready_o | output | 1 | Beat accepted when high together with valid |
| in_row_i | input | ROW_W | Row address of the beat |
| in_sig_i | input | LANES*8 | First samples (signal plus pedestal), lane 0 in the low byte |
| in_ped_i | input | LANES*8 | Second samples (pedestal), lane 0 in the low byte |
| frame_clr_i | input | 1 | Empties the hit memory and clears the overflow flag |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | ROW_W+COL_W+8 | Entry at the previous cycle's read address |
| hit_count_o | output | CNT_W | Number of stored entries |
| overflow_o | output | 1 | At least one hit was dropped in this frame |

## Verification
The bench builds the block with N_COLS=16, LANES=4, ROW_W=4 and DEPTH=8. Each row is therefore four beats, which exercises the beat counter wrap and the column numbering on every row. Four lanes per beat let a single beat carry up to four hits, which brings the ready stall and the ascending write order within reach. An eight-entry memory fills exactly, or overflows, within one or two rows, so the full-but-not-overflowed boundary and the drop rule are both reached without long frames.

// File: rtl/cdzs_pkg.sv
package cdzs_pkg;
  localparam int SAMPLE_W = 8;
  localparam int DIFF_W   = SAMPLE_W + 1;

  typedef logic [SAMPLE_W-1:0]      sample_t;
  typedef logic signed [DIFF_W-1:0] diff_t;

  function automatic diff_t cds_sub(sample_t s_first, sample_t s_second);
    return diff_t'({1'b0, s_first}) - diff_t'({1'b0, s_second});
  endfunction
endpackage

// File: rtl/cdzs_lane.sv
module cdzs_lane
  import cdzs_pkg::*;
(
  input  sample_t sig_i,
  input  sample_t ped_i,
  input  sample_t thr_i,
  output logic    hit_o,
  output sample_t amp_o
);
  diff_t diff;
  diff_t thr_s;

  always_comb begin
    diff  = cds_sub(sig_i, ped_i);
    thr_s = diff_t'({1'b0, thr_i});
    // thr_s >= 0, so a pass implies a positive difference <= 255
    hit_o = (diff > thr_s);
    amp_o = diff[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/cdzs_scan.sv
module cdzs_scan
  import cdzs_pkg::*;
#(
  parameter int LANES = 8,
  parameter int COL_W = 7,
  parameter int ROW_W = 12,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [LANES-1:0]          hit_i,
  input  logic [LANES*SAMPLE_W-1:0] amp_i,
  input  logic [ROW_W-1:0]          row_i,
  input  logic [COL_W-1:0]          base_i,
  output logic                      ready_o,
  output logic                      wr_o,
  output logic [ROW_W-1:0]          wr_row_o,
  output logic [COL_W-1:0]          wr_col_o,
  output sample_t                   wr_amp_o
);
  logic [LANES-1:0]          mask_q;
  logic [LANES*SAMPLE_W-1:0] amp_q;
  logic [ROW_W-1:0]          row_q;
  logic [COL_W-1:0]          base_q;
  logic [LANES-1:0]          mask_rest;
  logic [LANE_W-1:0]         sel;

  // lowest pending lane wins
  always_comb begin
    sel = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask_q[i]) sel = LANE_W'(i);
    end
  end

  assign mask_rest = mask_q & (mask_q - LANES'(1));
  assign ready_o   = (mask_rest == '0);
  assign wr_o      = (mask_q != '0);
  assign wr_row_o  = row_q;
  assign wr_col_o  = base_q + COL_W'(sel);
  assign wr_amp_o  = amp_q[sel*SAMPLE_W +: SAMPLE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      amp_q  <= '0;
      row_q  <= '0;
      base_q <= '0;
    end else if (load_i) begin
      mask_q <= hit_i;
      amp_q  <= amp_i;
      row_q  <= row_i;
      base_q <= base_i;
    end else begin
      mask_q <= mask_rest;
    end
  end
endmodule

// File: rtl/cdzs_store.sv
module cdzs_store #(
  parameter int DEPTH = 64,
  parameter int ENT_W = 27,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ENT_W-1:0]  wr_data_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [ENT_W-1:0]  rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] count_q;
  logic             ovf_q;
  logic             full;
  logic             do_wr;

  assign full  = (count_q == CNT_W'(DEPTH));
  assign do_wr = wr_i && !clr_i && !full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else if (clr_i) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else if (wr_i) begin
      if (full) ovf_q <= 1'b1;
      else      count_q <= count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem[count_q[ADDR_W-1:0]] <= wr_data_i;
    rd_data_o <= mem[rd_addr_i];
  end

  assign count_o = count_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/cds_hit_finder.sv
module cds_hit_finder
  import cdzs_pkg::*;
#(
  parameter int N_COLS = 128,
  parameter int LANES  = 8,
  parameter int ROW_W  = 12,
  parameter int DEPTH  = 64,
  localparam int BEATS  = N_COLS / LANES,
  localparam int COL_W  = (N_COLS > 1) ? $clog2(N_COLS) : 1,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ENT_W  = ROW_W + COL_W + SAMPLE_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      thr_we_i,
  input  logic [SAMPLE_W-1:0]       thr_i,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic [ROW_W-1:0]          in_row_i,
  input  logic [LANES*SAMPLE_W-1:0] in_sig_i,
  input  logic [LANES*SAMPLE_W-1:0] in_ped_i,
  input  logic                      frame_clr_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [ENT_W-1:0]          rd_data_o,
  output logic [CNT_W-1:0]          hit_count_o,
  output logic                      overflow_o
);
  sample_t                   thr_q;
  logic                      accept;
  logic [LANES-1:0]          hit;
  logic [LANES*SAMPLE_W-1:0] amp;
  logic [COL_W-1:0]          col_base;
  logic                      wr;
  logic [ROW_W-1:0]          wr_row;
  logic [COL_W-1:0]          wr_col;
  sample_t                   wr_amp;

  assign accept = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       thr_q <= '0;
    else if (thr_we_i) thr_q <= thr_i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    cdzs_lane u_lane (
      .sig_i (in_sig_i[l*SAMPLE_W +: SAMPLE_W]),
      .ped_i (in_ped_i[l*SAMPLE_W +: SAMPLE_W]),
      .thr_i (thr_q),
      .hit_o (hit[l]),
      .amp_o (amp[l*SAMPLE_W +: SAMPLE_W])
    );
  end

  if (BEATS > 1) begin : g_serial
    localparam int BEAT_W = $clog2(BEATS);
    logic [BEAT_W-1:0] beat_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) beat_q <= '0;
      else if (accept) beat_q <= (beat_q == BEAT_W'(BEATS - 1)) ? '0 : beat_q + BEAT_W'(1);
    end
    assign col_base = COL_W'(beat_q) * COL_W'(LANES);
  end else begin : g_parallel
    assign col_base = '0;
  end

  cdzs_scan #(
    .LANES (LANES),
    .COL_W (COL_W),
    .ROW_W (ROW_W)
  ) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .hit_i    (hit),
    .amp_i    (amp),
    .row_i    (in_row_i),
    .base_i   (col_base),
    .ready_o  (in_ready_o),
    .wr_o     (wr),
    .wr_row_o (wr_row),
    .wr_col_o (wr_col),
    .wr_amp_o (wr_amp)
  );

  cdzs_store #(
    .DEPTH (DEPTH),
    .ENT_W (ENT_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .wr_data_i ({wr_row, wr_col, wr_amp}),
    .clr_i     (frame_clr_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .count_o   (hit_count_o),
    .ovf_o     (overflow_o)
  );
endmodule

// File: rtl/cds_hit_finder_chk.sv
module cds_hit_finder_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_clr_i,
  input logic [CNT_W-1:0] hit_count_o,
  input logic             overflow_o
);
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_count_o <= CNT_W'(DEPTH)); // R9
  AST_OVF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !frame_clr_i |=> overflow_o); // R9
  AST_OVF_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> hit_count_o == CNT_W'(DEPTH)); // R9
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_clr_i |=> hit_count_o == '0 && !overflow_o); // R10
  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_clr_i |=> (hit_count_o - $past(hit_count_o)) <= CNT_W'(1)); // R8
endmodule

bind cds_hit_finder cds_hit_finder_chk #(
  .DEPTH (DEPTH),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_clr_i (frame_clr_i),
  .hit_count_o (hit_count_o),
  .overflow_o  (overflow_o)
);

// File: tb/cds_hit_finder_tb.sv
module cds_hit_finder_tb;
  localparam int CLK_P  = 10;
  localparam int N_COLS = 16;
  localparam int LANES  = 4;
  localparam int ROW_W  = 4;
  localparam int DEPTH  = 8;
  localparam int BEATS  = N_COLS / LANES;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = 4;
  localparam int ENT_W  = 16;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 thr_we = 1'b0;
  logic [7:0]           thr = '0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [ROW_W-1:0]     in_row = '0;
  logic [LANES*8-1:0]   in_sig = '0;
  logic [LANES*8-1:0]   in_ped = '0;
  logic                 frame_clr = 1'b0;
  logic [ADDR_W-1:0]    rd_addr = '0;
  logic [ENT_W-1:0]     rd_data;
  logic [CNT_W-1:0]     hit_count;
  logic                 overflow;

  int n_chk = 0;
  int n_fail = 0;
  logic [ENT_W-1:0] exp_mem [DEPTH];
  int   exp_cnt = 0;
  bit   exp_ovf = 1'b0;
  int   thr_m = 0;
  logic [7:0] sig_a [N_COLS];
  logic [7:0] ped_a [N_COLS];

  always #(CLK_P/2) clk = ~clk;

  cds_hit_finder #(
    .N_COLS (N_COLS),
    .LANES  (LANES),
    .ROW_W  (ROW_W),
    .DEPTH  (DEPTH)
  ) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .thr_we_i    (thr_we),
    .thr_i       (thr),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_row_i    (in_row),
    .in_sig_i    (in_sig),
    .in_ped_i    (in_ped),
    .frame_clr_i (frame_clr),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .hit_count_o (hit_count),
    .overflow_o  (overflow)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int diff_of(int c);
    return int'(sig_a[c]) - int'(ped_a[c]);
  endfunction

  function automatic bit is_hit(int c);
    return diff_of(c) > thr_m;
  endfunction

  task automatic model_hit(int row, int c);
    logic [ENT_W-1:0] e;
    e = {4'(row), 4'(c), 8'(diff_of(c))};
    if (exp_cnt < DEPTH) begin
      exp_mem[exp_cnt] = e;
      exp_cnt++;
    end else begin
      exp_ovf = 1'b1;
    end
  endtask

  // called at a negedge; returns at a negedge
  task automatic send_row(int row);
    for (int b = 0; b < BEATS; b++) begin
      int nh = 0;
      in_valid = 1'b1;
      in_row   = 4'(row);
      for (int l = 0; l < LANES; l++) begin
        in_sig[l*8 +: 8] = sig_a[b*LANES + l];
        in_ped[l*8 +: 8] = ped_a[b*LANES + l];
      end
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      for (int l = 0; l < LANES; l++) begin
        if (is_hit(b*LANES + l)) begin
          model_hit(row, b*LANES + l);
          nh++;
        end
      end
      @(negedge clk);
      in_valid = 1'b0;
      check("R8 ready after beat", 32'(in_ready), 32'(nh <= 1));
    end
    repeat (LANES + 2) @(negedge clk);
  endtask

  task automatic check_frame();
    check("R9 hit count", 32'(hit_count), 32'(exp_cnt));
    check("R9 overflow flag", 32'(overflow), 32'(exp_ovf));
    for (int a = 0; a < exp_cnt; a++) begin
      rd_addr = 3'(a);
      @(negedge clk);
      check("R2 R6 R7 R11 entry", 32'(rd_data), 32'(exp_mem[a]));
    end
  endtask

  task automatic clear_frame();
    frame_clr = 1'b1;
    @(negedge clk);
    frame_clr = 1'b0;
    exp_cnt = 0;
    exp_ovf = 1'b0;
    check("R10 count cleared", 32'(hit_count), 32'd0);
    check("R10 overflow cleared", 32'(overflow), 32'd0);
  endtask

  task automatic set_thr(int v);
    thr_we = 1'b1;
    thr    = 8'(v);
    @(negedge clk);
    thr_we = 1'b0;
    thr_m  = v;
  endtask

  task automatic fill(int s, int p);
    for (int c = 0; c < N_COLS; c++) begin
      sig_a[c] = 8'(s);
      ped_a[c] = 8'(p);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, default threshold 0
    check("R1 count", 32'(hit_count), 32'd0);
    check("R1 overflow", 32'(overflow), 32'd0);
    check("R1 ready", 32'(in_ready), 32'd1);
    fill(40, 40);
    sig_a[0] = 8'd41;
    send_row(2);
    check("R1 threshold zero passes diff 1", 32'(hit_count), 32'd1);
    check_frame();
    clear_frame();

    // R3 R4 R7 R9: exact fill to DEPTH without overflow
    set_thr(10);
    fill(50, 50);
    sig_a[0] = 8'd60;                  // equal to threshold, R3
    sig_a[1] = 8'd61;
    sig_a[2] = 8'd45;                  // negative, R4
    sig_a[3] = 8'd0;  ped_a[3] = 8'd255;
    sig_a[4] = 8'd70;
    sig_a[5] = 8'd80;
    sig_a[6] = 8'd90;
    sig_a[7] = 8'd255; ped_a[7] = 8'd0;
    sig_a[9] = 8'd61;
    sig_a[15] = 8'd255; ped_a[15] = 8'd0;
    send_row(5);
    fill(50, 50);
    sig_a[3] = 8'd100;
    send_row(9);
    check("R9 full without overflow", 32'(overflow), 32'd0);
    check_frame();
    clear_frame();

    // R4: zero threshold, no positive difference
    set_thr(0);
    for (int c = 0; c < N_COLS; c++) begin
      ped_a[c] = 8'd100;
      sig_a[c] = 8'($urandom_range(0, 100));
    end
    send_row(7);
    check("R4 no hit for diff <= 0", 32'(hit_count), 32'd0);

    // R10: after clear, next hit lands at address 0
    clear_frame();
    fill(30, 30);
    sig_a[12] = 8'd31;
    send_row(11);
    check_frame();
    clear_frame();

    // R5: threshold change alone decides the outcome
    fill(25, 20);
    set_thr(5);
    send_row(1);
    check("R5 thr 5 blocks diff 5", 32'(hit_count), 32'd0);
    set_thr(4);
    send_row(3);
    check("R5 R9 thr 4 passes all, overflow", 32'(overflow), 32'd1);
    check_frame();
    send_row(4);
    check("R9 overflow held", 32'(overflow), 32'd1);
    clear_frame();

    // random frames
    for (int f = 0; f < 40; f++) begin
      int nrows;
      set_thr(int'($urandom_range(0, 40)));
      nrows = int'($urandom_range(1, 3));
      for (int r = 0; r < nrows; r++) begin
        for (int c = 0; c < N_COLS; c++) begin
          int p;
          int s;
          p = int'($urandom_range(0, 255));
          s = p + int'($urandom_range(0, 120)) - 60;
          if (s < 0) s = 0;
          if (s > 255) s = 255;
          ped_a[c] = 8'(p);
          sig_a[c] = 8'(s);
        end
        send_row(int'($urandom_range(0, 15)));
      end
      check_frame();
      clear_frame();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule